// File: doc/BRIEF.md
# Addressed Serial Register Loader

This block is the programming port for a pair of frequency synthesizers, one IF and one RF. A host sends a 24-bit word over three wires: a serial clock, a serial data line and a load strobe. Each serial clock rise shifts one bit into a single shift register, with the most significant bit sent first. When the load strobe rises, the word is committed to one of four holding registers.

The two lowest bits of the word are an address and pick the destination. The bits above them are the payload. A reference-divider register uses a 14-bit field. A feedback-divider register uses a 6-bit A field and a 12-bit B field. Each destination has an update strobe one system clock wide, so the divider that uses the register knows when to reload.

All three serial pins are asynchronous to the system clock. They are resynchronized inside the block and their edges are detected in the system clock domain. The serial clock must therefore be slow compared with the system clock.

Top module: `serial_reg_loader`

## Requirements
- R1: Each rising edge of the serial clock shifts one bit of the serial data into a 24-bit register, most significant bit first. Only the last 24 bits shifted in are kept; earlier bits drop out.
- R2: A register write happens only on a rising edge of the load strobe. Holding the strobe high, or lowering it, writes nothing, even if serial bits arrive in the meantime.
- R3: Word bits [1:0] choose the destination: 0 is IF reference, 1 is IF feedback, 2 is RF reference and 3 is RF feedback.
- R4: A reference output takes word bits [15:2] as its 14-bit value. Word bits [23:16] have no effect on it.
- R5: A feedback output takes word bits [7:2] as its A field and word bits [19:8] as its B field. Word bits [23:20] have no effect on it.
- R6: A load changes only the addressed register; the other three keep their values.
- R7: A load raises bit d of `upd_o`, where d is the address (0 to 3). The pulse is exactly one system clock wide, and in that same cycle the new value first appears. No other bit of `upd_o` rises.
- R8: While reset is low, all four registers read zero and `upd_o` is zero.
- R9: Serial clock edges with no load-strobe rise leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| sload_i | input | 1 | Load strobe, asynchronous; its rise commits the word |
| if_ref_o | output | 14 | IF reference divider value |
| if_fb_a_o | output | 6 | IF feedback divider A field |
| if_fb_b_o | output | 12 | IF feedback divider B field |
| rf_ref_o | output | 14 | RF reference divider value |
| rf_fb_a_o | output | 6 | RF feedback divider A field |
| rf_fb_b_o | output | 12 | RF feedback divider B field |
| upd_o | output | 4 | One-cycle update strobe per destination, bit index equals address |

## Verification
The assertions check four things on every cycle. No register changes without its own strobe. Strobes are one-hot and one cycle wide. Each strobed register holds the payload that sat in the shift register in the cycle before, and that word's address matches the strobe. Each synchronized serial clock rise shifts the register one place with the new bit at the bottom. Only the bench scenarios show the end-to-end behaviour seen at the pins: the order of bits across a whole word, overlong words, writes only on the strobe's rising edge, and the field positions at the outputs.

// File: rtl/srl_pkg.sv
package srl_pkg;
  typedef enum logic [1:0] {
    DEST_IF_REF = 2'd0,
    DEST_IF_FB  = 2'd1,
    DEST_RF_REF = 2'd2,
    DEST_RF_FB  = 2'd3
  } dest_e;
endpackage

// File: rtl/srl_sync.sv
module srl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/srl_edge.sv
module srl_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/srl_shift.sv
module srl_shift #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sh_q <= '0;
    else if (en_i) sh_q <= {sh_q[W-2:0], d_i};
  end

  assign q_o = sh_q;
endmodule

// File: rtl/srl_latch_bank.sv
module srl_latch_bank #(
  parameter int SEL_W  = 2,
  parameter int DATA_W = 18,
  localparam int NUM_DEST = 1 << SEL_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_i,
  input  logic [SEL_W-1:0]                 sel_i,
  input  logic [DATA_W-1:0]                data_i,
  output logic [NUM_DEST-1:0][DATA_W-1:0]  lat_o,
  output logic [NUM_DEST-1:0]              upd_o
);
  for (genvar g = 0; g < NUM_DEST; g++) begin : g_dest
    logic              hit;
    logic [DATA_W-1:0] lat_q;
    logic              upd_q;

    assign hit = wr_i && (sel_i == SEL_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lat_q <= '0;
        upd_q <= 1'b0;
      end else begin
        upd_q <= hit;
        if (hit) lat_q <= data_i;
      end
    end

    assign lat_o[g] = lat_q;
    assign upd_o[g] = upd_q;
  end
endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader
  import srl_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int CTRL_W      = 2,
  parameter int REF_W       = 14,
  parameter int A_W         = 6,
  parameter int B_W         = 12,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_DEST   = 1 << CTRL_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sclk_i,
  input  logic                sdata_i,
  input  logic                sload_i,
  output logic [REF_W-1:0]    if_ref_o,
  output logic [A_W-1:0]      if_fb_a_o,
  output logic [B_W-1:0]      if_fb_b_o,
  output logic [REF_W-1:0]    rf_ref_o,
  output logic [A_W-1:0]      rf_fb_a_o,
  output logic [B_W-1:0]      rf_fb_b_o,
  output logic [NUM_DEST-1:0] upd_o
);
  localparam int FB_W   = A_W + B_W;
  localparam int DATA_W = (FB_W > REF_W) ? FB_W : REF_W;

  logic                             sclk_s, sdata_s, sload_s;
  logic                             shift_en, load_rise;
  logic [WORD_W-1:0]                shift_q;
  logic [NUM_DEST-1:0][DATA_W-1:0]  lat_q;
  logic                             unused_bits;

  srl_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, sdata_i, sload_i}),
    .q_o   ({sclk_s, sdata_s, sload_s})
  );

  srl_edge i_sclk_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sclk_s),
    .rise_o(shift_en)
  );

  srl_edge i_load_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sload_s),
    .rise_o(load_rise)
  );

  srl_shift #(.W(WORD_W)) i_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (shift_en),
    .d_i   (sdata_s),
    .q_o   (shift_q)
  );

  srl_latch_bank #(.SEL_W(CTRL_W), .DATA_W(DATA_W)) i_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (load_rise),
    .sel_i (shift_q[CTRL_W-1:0]),
    .data_i(shift_q[CTRL_W +: DATA_W]),
    .lat_o (lat_q),
    .upd_o (upd_o)
  );

  // Field slicing: B sits directly above A in a feedback word
  assign if_ref_o  = lat_q[int'(DEST_IF_REF)][REF_W-1:0];
  assign if_fb_a_o = lat_q[int'(DEST_IF_FB)][A_W-1:0];
  assign if_fb_b_o = lat_q[int'(DEST_IF_FB)][A_W +: B_W];
  assign rf_ref_o  = lat_q[int'(DEST_RF_REF)][REF_W-1:0];
  assign rf_fb_a_o = lat_q[int'(DEST_RF_FB)][A_W-1:0];
  assign rf_fb_b_o = lat_q[int'(DEST_RF_FB)][A_W +: B_W];

  assign unused_bits = ^{shift_q[WORD_W-1:CTRL_W+DATA_W],
                         lat_q[int'(DEST_IF_REF)][DATA_W-1:REF_W],
                         lat_q[int'(DEST_RF_REF)][DATA_W-1:REF_W]};
endmodule

// File: rtl/srl_checker.sv
module srl_checker #(
  parameter int WORD_W   = 24,
  parameter int CTRL_W   = 2,
  parameter int DATA_W   = 18,
  parameter int NUM_DEST = 4
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            shift_en,
  input logic                            sdata_s,
  input logic                            load_rise,
  input logic [WORD_W-1:0]               shift_q,
  input logic [NUM_DEST-1:0][DATA_W-1:0] lat_q,
  input logic [NUM_DEST-1:0]             upd_o
);
  // R1
  p_shift_msb_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en |=> shift_q == {$past(shift_q[WORD_W-2:0]), $past(sdata_s)})
    else $error("p_shift_msb_first_r1");

  // R7
  p_upd_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(upd_o))
    else $error("p_upd_onehot_r7");

  // R8
  p_reset_clear_r8: assert property (@(posedge clk_i)
    (!rst_ni && $past(!rst_ni)) |-> (lat_q == '0 && upd_o == '0))
    else $error("p_reset_clear_r8");

  for (genvar g = 0; g < NUM_DEST; g++) begin : g_chk
    // R7
    p_upd_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_o[g] |=> !upd_o[g])
      else $error("p_upd_single_r7");

    // R6 / R9
    p_hold_unless_upd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lat_q[g] != $past(lat_q[g])) |-> upd_o[g])
      else $error("p_hold_unless_upd_r6");

    // R3 / R2
    p_dest_payload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_o[g] |-> ($past(load_rise) &&
                    $past(shift_q[CTRL_W-1:0]) == CTRL_W'(g) &&
                    lat_q[g] == $past(shift_q[CTRL_W +: DATA_W])))
      else $error("p_dest_payload_r3");
  end
endmodule

bind serial_reg_loader srl_checker #(
  .WORD_W  (WORD_W),
  .CTRL_W  (CTRL_W),
  .DATA_W  (DATA_W),
  .NUM_DEST(NUM_DEST)
) i_srl_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .shift_en (shift_en),
  .sdata_s  (sdata_s),
  .load_rise(load_rise),
  .shift_q  (shift_q),
  .lat_q    (lat_q),
  .upd_o    (upd_o)
);

// File: tb/test_serial_reg_loader.sv
module test_serial_reg_loader;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, sdata = 1'b0, sload = 1'b0;
  logic [13:0] if_ref, rf_ref;
  logic [5:0]  if_a, rf_a;
  logic [11:0] if_b, rf_b;
  logic [3:0]  upd;

  int n_checks = 0;
  int n_errors = 0;
  logic [23:0] exp_word [4];
  int upd_cnt [4];
  int exp_cnt [4];
  int run_len [4];
  int max_run [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_reg_loader i_serial_reg_loader (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .sclk_i   (sclk),
    .sdata_i  (sdata),
    .sload_i  (sload),
    .if_ref_o (if_ref),
    .if_fb_a_o(if_a),
    .if_fb_b_o(if_b),
    .rf_ref_o (rf_ref),
    .rf_fb_a_o(rf_a),
    .rf_fb_b_o(rf_b),
    .upd_o    (upd)
  );

  always @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (rst_n && upd[i]) begin
        upd_cnt[i] = upd_cnt[i] + 1;
        run_len[i] = run_len[i] + 1;
        if (run_len[i] > max_run[i]) max_run[i] = run_len[i];
      end else begin
        run_len[i] = 0;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdata = b;
    wait_clk(4);
    sclk = 1'b1;
    wait_clk(4);
    sclk = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic do_load();
    wait_clk(4);
    sload = 1'b1;
    wait_clk(6);
    sload = 1'b0;
    wait_clk(6);
  endtask

  // Compare all outputs against the model words (field positions per R4, R5)
  task automatic check_outputs(input string req);
    chk(req, "if_ref", 32'(if_ref), 32'(exp_word[0][15:2]));
    chk(req, "if_a",   32'(if_a),   32'(exp_word[1][7:2]));
    chk(req, "if_b",   32'(if_b),   32'(exp_word[1][19:8]));
    chk(req, "rf_ref", 32'(rf_ref), 32'(exp_word[2][15:2]));
    chk(req, "rf_a",   32'(rf_a),   32'(exp_word[3][7:2]));
    chk(req, "rf_b",   32'(rf_b),   32'(exp_word[3][19:8]));
  endtask

  task automatic check_counts(input string req);
    for (int i = 0; i < 4; i++) chk(req, "upd count", 32'(upd_cnt[i]), 32'(exp_cnt[i]));
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      exp_word[i] = '0; upd_cnt[i] = 0; exp_cnt[i] = 0; run_len[i] = 0; max_run[i] = 0;
    end
    wait_clk(3);
    // R8: reset state
    check_outputs("R8");
    chk("R8", "upd in reset", 32'(upd), 32'h0);
    rst_n = 1'b1;
    wait_clk(3);

    // R3 R4 R5 R6 R7: sweep of destinations and payload patterns
    for (int d = 0; d < 4; d++) begin
      for (int p = 0; p < 8; p++) begin
        logic [21:0] pat;
        logic [23:0] w;
        case (p)
          0: pat = 22'h3FFFFF;
          1: pat = 22'h155555;
          2: pat = 22'h2AAAAA;
          3: pat = 22'h000000;
          default: pat = (22'h3 << (p * 3 + d)) ^ 22'(d * 32'h2F1 + p);
        endcase
        w = {pat, 2'(d)};
        send_bits(32'(w), 24);
        do_load();
        exp_word[d] = w;
        exp_cnt[d]++;
        check_outputs("R3");
        check_counts("R7");
      end
    end
    for (int i = 0; i < 4; i++) chk("R7", "upd pulse width", 32'(max_run[i]), 32'd1);

    // R1: overlong word, leading bits drop out
    begin
      logic [23:0] w;
      w = {22'h2C3A5B, 2'd2};
      send_bits(32'hF, 4);
      send_bits(32'(w), 24);
      do_load();
      exp_word[2] = w;
      exp_cnt[2]++;
      check_outputs("R1");
      check_counts("R1");
    end

    // R9: serial traffic with no load leaves outputs unchanged
    send_bits(32'h00ABCDE1, 24);
    wait_clk(8);
    check_outputs("R9");
    check_counts("R9");

    // R2: write on load rise only; shifting while high and the fall write nothing
    begin
      logic [23:0] w1, w2;
      w1 = {22'h0F0F0F, 2'd0};
      w2 = {22'h123456, 2'd0};
      send_bits(32'(w1), 24);
      wait_clk(4);
      sload = 1'b1;
      wait_clk(6);
      exp_word[0] = w1;
      exp_cnt[0]++;
      send_bits(32'(w2), 24);
      wait_clk(4);
      sload = 1'b0;
      wait_clk(8);
      check_outputs("R2");
      check_counts("R2");
    end

    // R6: load to one feedback register leaves the rest alone
    begin
      logic [23:0] w;
      w = {22'h3C0001, 2'd1};
      send_bits(32'(w), 24);
      do_load();
      exp_word[1] = w;
      exp_cnt[1]++;
      check_outputs("R6");
      check_counts("R6");
    end

    // R8: reset during operation clears everything
    rst_n = 1'b0;
    wait_clk(2);
    for (int i = 0; i < 4; i++) exp_word[i] = '0;
    check_outputs("R8");
    chk("R8", "upd in reset", 32'(upd), 32'h0);
    rst_n = 1'b1;
    wait_clk(2);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule